// File: doc/BRIEF.md
# Two-Pattern Scan Chain with Hold Stage

This block is a scan chain for at-speed delay testing in which every cell owns two storage elements: a shift flip-flop on the serial path and a hold stage behind it whose output drives the combinational logic under test. The hold stage keeps the logic inputs frozen while the shift flip-flops are reloaded. Two fully independent vectors can therefore be applied one after the other: a first vector that sets up the logic, then a second vector that launches transitions. The second vector has no required relation to the first, either by a one-bit shift or through the logic's own function.

A single `start` pulse runs the whole test. An internal sequencer shifts the first vector in, copies it into the hold stages, and shifts the second vector in while the hold stages keep the first. It then makes the hold stages follow the flip-flops so the transitions reach the logic, and finally loads the logic's response into the shift flip-flops. The captured response leaves on `scan_out` during the first shift phase of the next test, while that test's first vector enters on `scan_in`. A one-cycle `done` pulse marks the end of capture.

Top module: `escan_chain`

## Requirements
- R1: While reset is asserted and right after it is released, `logic_drive`, `scan_out` and `done` are all zero.
- R2: A `start` seen high in idle begins a first shift phase of exactly N clocks. Each clock takes one `scan_in` bit into cell 0 and moves every cell's bit to the next higher index, so the first bit sent ends up in cell N-1. One copy cycle follows, after which `logic_drive[i]` equals the bit held by cell i.
- R3: During the second shift phase, which lasts N clocks, and during the launch cycle that follows it, `logic_drive` holds the first vector unchanged.
- R4: After the launch cycle, `logic_drive` equals the second vector that was shifted in, with the same bit ordering as in R2.
- R5: In the capture cycle, which follows launch, each cell loads `logic_resp[i]`. During the next test's first shift phase, `scan_out` presents that response with cell N-1 first and one cell per clock, while the new first vector enters.
- R6: `done` is high for exactly one cycle, in the cycle after the capture edge. That is the cycle after the (2N+3)th rising edge that follows the edge on which `start` was accepted. The block is idle again in that same cycle.
- R7: `start` has no effect while a test is in progress. The timing of `done` and the vectors on `logic_drive` are the same as without the extra pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan and test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a test when the block is idle |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data out of cell N-1 |
| logic_drive | output | N | Hold-stage outputs that feed the logic under test |
| logic_resp | input | N | Response of the logic under test |
| done | output | 1 | One-cycle pulse when capture completes |

## Verification
On every cycle, the bound checker confirms several properties: the logic inputs stay still across any shift clock, a hold update copies exactly the flip-flop contents, a capture copies exactly `logic_resp`, the serial path moves one position per shift, `done` is a single pulse that follows capture, and an active test never falls back to idle before capture. The bench scenarios are needed for the vector contents end to end. They show that a chosen first and second vector arrive on `logic_drive` with the stated bit ordering, that the response of a modelled logic function comes back in the right order during the next load, that the cycle count to `done` is exact, and that a `start` pulse in the middle of a test changes nothing.

// File: rtl/escan_pkg.sv
package escan_pkg;

  typedef enum logic [2:0] {
    P_IDLE    = 3'd0,
    P_LOAD1   = 3'd1,
    P_COPY    = 3'd2,
    P_LOAD2   = 3'd3,
    P_LAUNCH  = 3'd4,
    P_CAPTURE = 3'd5
  } esc_phase_e;

endpackage

// File: rtl/escan_cell.sv
module escan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic cap_en,
  input  logic hold_en,
  input  logic ser_in,
  input  logic resp_in,
  output logic ff_out,
  output logic hold_out
);

  logic ff_q, ff_d;
  logic hold_q, hold_d;

  // shift flip-flop: serial shift has priority, otherwise parallel capture
  always_comb begin
    ff_d = ff_q;
    if (shift_en) begin
      ff_d = ser_in;
    end else if (cap_en) begin
      ff_d = resp_in;
    end
  end

  // hold stage: follows the flip-flop only while enabled
  always_comb begin
    hold_d = hold_q;
    if (hold_en) begin
      hold_d = ff_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      ff_q   <= ff_d;
      hold_q <= hold_d;
    end
  end

  assign ff_out   = ff_q;
  assign hold_out = hold_q;

endmodule

// File: rtl/escan_seq.sv
module escan_seq
  import escan_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       shift_en,
  output logic       hold_en,
  output logic       cap_en,
  output logic       done,
  output esc_phase_e phase
);

  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  esc_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          last_bit;

  assign last_bit = (cnt_q == LAST);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (phase_q)
      P_IDLE: begin
        cnt_d = '0;
        if (start) begin
          phase_d = P_LOAD1;
        end
      end
      P_LOAD1: begin
        if (last_bit) begin
          cnt_d   = '0;
          phase_d = P_COPY;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      P_COPY: begin
        phase_d = P_LOAD2;
      end
      P_LOAD2: begin
        if (last_bit) begin
          cnt_d   = '0;
          phase_d = P_LAUNCH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      P_LAUNCH: begin
        phase_d = P_CAPTURE;
      end
      P_CAPTURE: begin
        phase_d = P_IDLE;
        done_d  = 1'b1;
      end
      default: begin
        phase_d = P_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= P_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign shift_en = (phase_q == P_LOAD1) || (phase_q == P_LOAD2);
  assign hold_en  = (phase_q == P_COPY) || (phase_q == P_LAUNCH);
  assign cap_en   = (phase_q == P_CAPTURE);
  assign done     = done_q;
  assign phase    = phase_q;

endmodule

// File: rtl/escan_chain.sv
module escan_chain
  import escan_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         scan_in,
  output logic         scan_out,
  output logic [N-1:0] logic_drive,
  input  logic [N-1:0] logic_resp,
  output logic         done
);

  logic         shift_en;
  logic         hold_en;
  logic         cap_en;
  esc_phase_e   phase;
  logic [N-1:0] ff_vec;
  logic [N-1:0] ser_vec;

  escan_seq #(.N(N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .shift_en (shift_en),
    .hold_en  (hold_en),
    .cap_en   (cap_en),
    .done     (done),
    .phase    (phase)
  );

  // serial path: cell 0 takes scan_in, cell i takes cell i-1
  assign ser_vec = {ff_vec[N-2:0], scan_in};

  for (genvar gi = 0; gi < N; gi++) begin : g_cell
    escan_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .cap_en   (cap_en),
      .hold_en  (hold_en),
      .ser_in   (ser_vec[gi]),
      .resp_in  (logic_resp[gi]),
      .ff_out   (ff_vec[gi]),
      .hold_out (logic_drive[gi])
    );
  end

  assign scan_out = ff_vec[N-1];

endmodule

// File: rtl/escan_chain_chk.sv
module escan_chain_chk
  import escan_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         shift_en,
  input logic         hold_en,
  input logic         cap_en,
  input logic         done,
  input esc_phase_e   phase,
  input logic [N-1:0] ff_vec,
  input logic [N-1:0] drive,
  input logic [N-1:0] resp
);

  p_drive_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(drive));

  p_hold_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_en |=> (drive == $past(ff_vec)));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (ff_vec == $past(resp)));

  p_shift_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (ff_vec[N-1:1] == $past(ff_vec[N-2:0])));

  p_done_after_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> done);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_IDLE && !start) |=> (phase == P_IDLE));

  p_busy_no_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != P_IDLE && phase != P_CAPTURE) |=> (phase != P_IDLE));

endmodule

bind escan_chain escan_chain_chk #(.N(N)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .shift_en (shift_en),
  .hold_en  (hold_en),
  .cap_en   (cap_en),
  .done     (done),
  .phase    (phase),
  .ff_vec   (ff_vec),
  .drive    (logic_drive),
  .resp     (logic_resp)
);

// File: tb/test_escan_chain.sv
module test_escan_chain;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         scan_in = 1'b0;
  logic         scan_out;
  logic [N-1:0] logic_drive;
  logic [N-1:0] logic_resp;
  logic         done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [N-1:0] exp_q[$];

  always #5 clk = ~clk;

  // model of the logic under test: rotate left, then invert alternate bits
  function automatic logic [N-1:0] lut_model(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]} ^ {(N/2){2'b01}};
  endfunction

  assign logic_resp = lut_model(logic_drive);

  escan_chain #(.N(N)) i_escan_chain (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .scan_in     (scan_in),
    .scan_out    (scan_out),
    .logic_drive (logic_drive),
    .logic_resp  (logic_resp),
    .done        (done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: runs one complete test and pushes the expected later unload
  task automatic run_test(input logic [N-1:0] v1, input logic [N-1:0] v2,
                          input bit poke);
    @(negedge clk);
    start = 1'b1;
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      start   = 1'b0;
      scan_in = v1[N-1-j];
    end
    @(negedge clk);            // copy cycle
    scan_in = 1'b0;
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      check(logic_drive == v1, "R2/R3 first vector held", logic_drive, v1);
      scan_in = v2[N-1-j];
      if (poke) start = (j == 2);
    end
    @(negedge clk);            // launch cycle
    start = 1'b0;
    check(logic_drive == v1, "R3 held through launch cycle", logic_drive, v1);
    @(negedge clk);            // capture cycle
    check(logic_drive == v2, "R4 second vector applied", logic_drive, v2);
    check(done == 1'b0, "R6 done low during capture", N'(done), '0);
    @(negedge clk);
    check(done == 1'b1, "R6 done pulse after capture", N'(done), N'(1));
    @(negedge clk);
    check(done == 1'b0, "R6 done lasts one cycle", N'(done), '0);
    if (poke) check(logic_drive == v2, "R7 mid-test start ignored", logic_drive, v2);
    exp_q.push_back(lut_model(v2));
  endtask

  // monitor: collects the unloaded response and compares with the scoreboard
  initial begin
    int busy;
    int bitpos;
    logic [N-1:0] got;
    logic [N-1:0] exp;
    busy = 0;
    bitpos = 0;
    got = '0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      #2;
      if (busy > 0) begin
        if (bitpos < N) begin
          got[N-1-bitpos] = scan_out;
          bitpos++;
          if (bitpos == N) begin
            if (exp_q.size() == 0) begin
              check(1'b0, "R5 unload with no expected item", got, '0);
            end else begin
              exp = exp_q.pop_front();
              check(got == exp, "R5 response unloaded MSB first", got, exp);
            end
          end
        end
        busy--;
      end else if (start) begin
        busy = 2 * N + 3;
        bitpos = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(logic_drive == '0, "R1 drive zero in reset", logic_drive, '0);
    check(scan_out == 1'b0, "R1 scan_out zero in reset", N'(scan_out), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done zero after reset", N'(done), '0);
    check(logic_drive == '0, "R1 drive zero after reset", logic_drive, '0);
    // start must be ignored-free idle: nothing moves without start
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R7 idle without start", N'(done), '0);
    exp_q.push_back('0);       // reset contents unloaded by the first test
    run_test(8'hA5, 8'h5A, 1'b0);
    run_test(8'h00, 8'hFF, 1'b0);
    run_test(8'hFF, 8'h00, 1'b0);
    run_test(8'h81, 8'h7E, 1'b1);
    run_test(8'h3C, 8'h3C, 1'b0);
    run_test(8'h01, 8'h80, 1'b0);
    run_test(8'h00, 8'h00, 1'b0);  // flush the last response
    repeat (2 * N + 10) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule